// File: doc/BRIEF.md
# NIC Interrupt Moderation Controller

This block raises and paces the host interrupt for a network interface. Receive and transmit engines send it event strobes. It keeps a register of pending interrupt causes and a mask register, and it drives one level interrupt line. It also runs four countdown timers. For each direction there is a delay timer, which restarts on every event, and an absolute timer, which runs from the first event of a burst. When any timer of a direction runs out, the block pulses a full (unaligned) descriptor-writeback request to that direction's engine. In the same cycle it posts that direction's timer cause, and the line rises at once even if the throttle is running.

Ordinary causes are gated in two ways. The first is the mask. The second is an interrupt throttle counter, which reloads every time the line rises and holds back further normal assertions until it has counted down. All timers advance on a free-running tick input with a period of 1024 ns. The host works the block through a small write port, which selects the mask, a write-one-to-clear on the causes, the four timer limits, or the throttle limit. A read-clear strobe empties the cause register.

Top module: `nic_irq_moderator`

## Requirements
- R1: In reset and after it, `irq_o`, `rx_flush_o`, `tx_flush_o` and `cause_o` are 0. The mask, every timer limit and the throttle limit are 0, and all counters are stopped.
- R2: A 1 on bit i of `cause_post_i` sets bit i of `cause_o` at the next edge. If that bit is unmasked and the throttle is idle, `irq_o` is high after the same edge.
- R3: A write with `cfg_sel_i`=0 loads the mask from `cfg_data_i[7:0]`. The line is re-evaluated at that edge: it rises if a pending cause becomes unmasked (throttle idle) and falls if no pending cause stays unmasked.
- R4: The receive delay timer (select 2) loads its limit on every `rx_pkt_i`. After that many tick cycles with no further packet, `rx_flush_o` pulses for one cycle and cause bit 7 (receive timer) is set.
- R5: The receive absolute timer (select 3) loads on a packet only when it is stopped. Later packets do not restart it, and it expires after its limit in ticks counted from the first packet.
- R6: The transmit delay timer (select 4) and the transmit absolute timer (select 5) follow the rules of R4 and R5 on `tx_pkt_i`. On expiry they pulse `tx_flush_o` and set cause bit 0 (transmit descriptor written).
- R7: A timer whose limit is 0 never starts and never expires.
- R8: A cause posted by a timer expiry asserts `irq_o` at the next edge, if that cause is unmasked, even while the throttle counter is running.
- R9: The throttle (select 6) loads its limit on each rising edge of `irq_o` and counts down on ticks. While it is nonzero, normal causes do not raise the line. The line rises in the first cycle after it reaches 0 if an unmasked cause is pending.
- R10: `tx_wb_done_i` sets cause bit 0 as a normal cause, under the mask and throttle gating.
- R11: A write with select 1 clears the cause bits set in `cfg_data_i[7:0]`, and `cause_rd_i` clears all of them. `irq_o` drops at that edge when no unmasked cause remains. A post in the same cycle wins over a clear.
- R12: When either timer of a direction expires, both timers of that direction stop, so the pair produces one flush per burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle time unit strobe (1024 ns) |
| rx_pkt_i | input | 1 | A packet was received |
| tx_pkt_i | input | 1 | A transmit descriptor was used |
| tx_wb_done_i | input | 1 | A transmit descriptor writeback completed |
| cause_post_i | input | CW | Normal cause strobes, one per cause bit |
| cause_rd_i | input | 1 | Read-clear of the cause register |
| cfg_we_i | input | 1 | Write strobe of the control port |
| cfg_sel_i | input | 3 | 0 mask, 1 clear, 2 rx delay, 3 rx absolute, 4 tx delay, 5 tx absolute, 6 throttle |
| cfg_data_i | input | DW | Write data |
| irq_o | output | 1 | Level interrupt to the host |
| rx_flush_o | output | 1 | Full receive writeback request, one-cycle pulse |
| tx_flush_o | output | 1 | Full transmit writeback request, one-cycle pulse |
| cause_o | output | CW | Pending cause register |

## Verification
Every result is registered. Cause bits, the line and mask effects appear one edge after the cycle that carried the stimulus. A timer with limit N expires in the cycle that carries its Nth tick, so its flush pulse and cause bit show after that cycle's edge. A line held back by the throttle rises one cycle after the counter has reached zero. All outputs are sampled a quarter period after each rising edge and compared with a behavioural model that is advanced once per edge. Directed checks sample in exactly those counted cycles to see each boundary: one tick before expiry, expiry itself, and the first cycle after throttle release.

// File: rtl/nim_pkg.sv
package nim_pkg;

  // cause bits decoded by the host driver
  localparam int TXDW_BIT = 0;
  localparam int RXT_BIT  = 7;

  // control port selects
  typedef enum logic [2:0] {
    SEL_MASK = 3'd0,
    SEL_CLR  = 3'd1,
    SEL_RXD  = 3'd2,
    SEL_RXA  = 3'd3,
    SEL_TXD  = 3'd4,
    SEL_TXA  = 3'd5,
    SEL_THR  = 3'd6
  } cfg_sel_e;

  // two directions, each with a delay and an absolute timer
  localparam int NPAIR = 2;
  localparam int NTMR  = 2 * NPAIR;

endpackage

// File: rtl/nim_timer.sv
module nim_timer #(
  parameter int TW      = 16,
  parameter bit RESTART = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          arm_i,
  input  logic          stop_i,
  input  logic [TW-1:0] limit_i,
  output logic          fire_o
);

  logic          run_q;
  logic [TW-1:0] cnt_q;
  logic          load;

  assign fire_o = run_q && tick_i && (cnt_q == TW'(1));
  assign load   = arm_i && (limit_i != '0) && (RESTART || !run_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (load) begin
      run_q <= 1'b1;
      cnt_q <= limit_i;
    end else if (run_q && tick_i) begin
      cnt_q <= cnt_q - TW'(1);
    end
  end

  // R12
  stop_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
    fire_o |=> !run_q);

  // R7
  zero_limit_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && limit_i == '0) |=> !run_q);

endmodule

// File: rtl/nim_throttle.sv
module nim_throttle #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [TW-1:0] limit_i,
  output logic          idle_o
);

  logic [TW-1:0] cnt_q;

  assign idle_o = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start_i)
      cnt_q <= limit_i;
    else if (!idle_o && tick_i)
      cnt_q <= cnt_q - TW'(1);
  end

  // R9
  busy_without_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (!idle_o && !tick_i && !start_i) |=> !idle_o);

endmodule

// File: rtl/nim_cause.sv
module nim_cause #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] post_i,
  input  logic [CW-1:0] clr_i,
  input  logic          rdclr_i,
  input  logic          mask_we_i,
  input  logic [CW-1:0] mask_i,
  input  logic          thr_idle_i,
  input  logic          imm_i,
  output logic [CW-1:0] cause_o,
  output logic          irq_o,
  output logic          rise_o
);

  logic [CW-1:0] cause_q, mask_q, cause_n, mask_n;
  logic          irq_q, irq_n, any_pend;

  always_comb begin
    cause_n  = (rdclr_i ? '0 : (cause_q & ~clr_i)) | post_i;
    mask_n   = mask_we_i ? mask_i : mask_q;
    any_pend = |(cause_n & mask_n);
    irq_n    = irq_q ? any_pend : (any_pend && (thr_idle_i || imm_i));
  end

  assign rise_o  = !irq_q && irq_n;
  assign cause_o = cause_q;
  assign irq_o   = irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cause_q <= '0;
      mask_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      cause_q <= cause_n;
      mask_q  <= mask_n;
      irq_q   <= irq_n;
    end
  end

  // R8
  rise_gated_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(thr_idle_i || imm_i));

  // R11
  line_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> ((cause_q & mask_q) != '0));

  // R2
  post_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (post_i != '0) |=> ((cause_q & $past(post_i)) == $past(post_i)));

endmodule

// File: rtl/nic_irq_moderator.sv
module nic_irq_moderator #(
  parameter int CW = 8,
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          rx_pkt_i,
  input  logic          tx_pkt_i,
  input  logic          tx_wb_done_i,
  input  logic [CW-1:0] cause_post_i,
  input  logic          cause_rd_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_sel_i,
  input  logic [DW-1:0] cfg_data_i,
  output logic          irq_o,
  output logic          rx_flush_o,
  output logic          tx_flush_o,
  output logic [CW-1:0] cause_o
);
  import nim_pkg::*;

  localparam int LW = (TW < DW) ? TW : DW;

  logic [TW-1:0]    lim_q [NTMR];
  logic [TW-1:0]    thr_lim_q;
  logic [NTMR-1:0]  fire;
  logic [NPAIR-1:0] pair_fire, pair_arm;
  logic [CW-1:0]    post, clr;
  logic             mask_we, thr_idle, rise, rx_fl_q, tx_fl_q;
  logic [TW-1:0]    wdata;

  assign wdata = TW'(cfg_data_i[LW-1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NTMR; i++) lim_q[i] <= '0;
      thr_lim_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_sel_e'(cfg_sel_i))
        SEL_RXD: lim_q[0] <= wdata;
        SEL_RXA: lim_q[1] <= wdata;
        SEL_TXD: lim_q[2] <= wdata;
        SEL_TXA: lim_q[3] <= wdata;
        SEL_THR: thr_lim_q <= wdata;
        default: ;
      endcase
    end
  end

  assign pair_arm = {tx_pkt_i, rx_pkt_i};

  genvar g;
  generate
    for (g = 0; g < NPAIR; g++) begin : g_pair
      assign pair_fire[g] = fire[2*g] | fire[2*g+1];
    end
    for (g = 0; g < NTMR; g++) begin : g_tmr
      nim_timer #(.TW(TW), .RESTART((g % 2) == 0)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .arm_i   (pair_arm[g/2]),
        .stop_i  (pair_fire[g/2]),
        .limit_i (lim_q[g]),
        .fire_o  (fire[g])
      );
    end
  endgenerate

  always_comb begin
    post = cause_post_i;
    if (tx_wb_done_i) post[TXDW_BIT] = 1'b1;
    if (pair_fire[0]) post[RXT_BIT]  = 1'b1;
    if (pair_fire[1]) post[TXDW_BIT] = 1'b1;
  end

  assign mask_we = cfg_we_i && (cfg_sel_e'(cfg_sel_i) == SEL_MASK);
  assign clr     = (cfg_we_i && (cfg_sel_e'(cfg_sel_i) == SEL_CLR)) ? cfg_data_i[CW-1:0] : '0;

  nim_throttle #(.TW(TW)) u_thr (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .start_i (rise),
    .limit_i (thr_lim_q),
    .idle_o  (thr_idle)
  );

  nim_cause #(.CW(CW)) u_cause (
    .clk        (clk),
    .rst        (rst),
    .post_i     (post),
    .clr_i      (clr),
    .rdclr_i    (cause_rd_i),
    .mask_we_i  (mask_we),
    .mask_i     (cfg_data_i[CW-1:0]),
    .thr_idle_i (thr_idle),
    .imm_i      (|pair_fire),
    .cause_o    (cause_o),
    .irq_o      (irq_o),
    .rise_o     (rise)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_fl_q <= 1'b0;
      tx_fl_q <= 1'b0;
    end else begin
      rx_fl_q <= pair_fire[0];
      tx_fl_q <= pair_fire[1];
    end
  end

  assign rx_flush_o = rx_fl_q;
  assign tx_flush_o = tx_fl_q;

  // R4
  rx_flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_flush_o |-> cause_o[RXT_BIT]);

  // R6
  tx_flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tx_flush_o |-> cause_o[TXDW_BIT]);

  // R4
  flush_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_flush_o |=> !rx_flush_o);

endmodule

// File: tb/nic_irq_moderator_bench.sv
module nic_irq_moderator_bench;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 0, rx_pkt_i = 0, tx_pkt_i = 0, tx_wb_done_i = 0;
  logic [7:0] cause_post_i = '0;
  logic       cause_rd_i = 0, cfg_we_i = 0;
  logic [2:0] cfg_sel_i = '0;
  logic [15:0] cfg_data_i = '0;
  logic       irq_o, rx_flush_o, tx_flush_o;
  logic [7:0] cause_o;

  int n_cmp = 0, n_bad = 0;
  bit started = 0;

  always #(CLK_P/2) clk = ~clk;

  nic_irq_moderator u_nic_irq_moderator (
    .clk(clk), .rst(rst), .tick_i(tick_i), .rx_pkt_i(rx_pkt_i),
    .tx_pkt_i(tx_pkt_i), .tx_wb_done_i(tx_wb_done_i),
    .cause_post_i(cause_post_i), .cause_rd_i(cause_rd_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
    .irq_o(irq_o), .rx_flush_o(rx_flush_o), .tx_flush_o(tx_flush_o),
    .cause_o(cause_o)
  );

  // ---------------- behavioural reference ----------------
  int m_lim [4];
  int m_cnt [4];
  bit m_run [4];
  int m_thr_lim, m_thr, m_mask, m_cause;
  bit m_irq, m_rxf, m_txf;

  always @(posedge clk) begin
    bit pf [2];
    bit ev, irqn;
    int post, clr, cn, mn;
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_lim[i] = 0; m_cnt[i] = 0; m_run[i] = 0; end
      m_thr_lim = 0; m_thr = 0; m_mask = 0; m_cause = 0;
      m_irq = 0; m_rxf = 0; m_txf = 0;
    end else begin
      for (int p = 0; p < 2; p++)
        pf[p] = (m_run[2*p] && tick_i && m_cnt[2*p] == 1) ||
                (m_run[2*p+1] && tick_i && m_cnt[2*p+1] == 1);
      for (int i = 0; i < 4; i++) begin
        ev = (i < 2) ? rx_pkt_i : tx_pkt_i;
        if (pf[i/2]) m_run[i] = 0;
        else if (ev && m_lim[i] != 0 && ((i % 2) == 0 || !m_run[i])) begin
          m_run[i] = 1; m_cnt[i] = m_lim[i];
        end else if (m_run[i] && tick_i) m_cnt[i] = m_cnt[i] - 1;
      end
      post = cause_post_i;
      if (tx_wb_done_i) post = post | 1;
      if (pf[0]) post = post | 8'h80;
      if (pf[1]) post = post | 1;
      clr = (cfg_we_i && cfg_sel_i == 1) ? cfg_data_i[7:0] : 0;
      cn  = cause_rd_i ? post : ((m_cause & ~clr & 8'hFF) | post);
      mn  = (cfg_we_i && cfg_sel_i == 0) ? cfg_data_i[7:0] : m_mask;
      if (m_irq) irqn = (cn & mn) != 0;
      else       irqn = ((cn & mn) != 0) && (m_thr == 0 || pf[0] || pf[1]);
      if (!m_irq && irqn) m_thr = m_thr_lim;
      else if (m_thr != 0 && tick_i) m_thr = m_thr - 1;
      m_cause = cn; m_mask = mn; m_irq = irqn;
      m_rxf = pf[0]; m_txf = pf[1];
      if (cfg_we_i && cfg_sel_i >= 2 && cfg_sel_i <= 5) m_lim[cfg_sel_i-2] = cfg_data_i;
      if (cfg_we_i && cfg_sel_i == 6) m_thr_lim = cfg_data_i;
    end
  end

  always @(posedge clk) begin
    #(CLK_P/4);
    if (started) begin
      n_cmp++;
      if (irq_o !== m_irq || rx_flush_o !== m_rxf || tx_flush_o !== m_txf ||
          cause_o !== m_cause[7:0]) begin
        n_bad++;
        $display("FAIL R2/R4/R6/R8/R9/R11 model: irq %0b/%0b rxf %0b/%0b txf %0b/%0b cause %02h/%02h (actual/expected)",
                 irq_o, m_irq, rx_flush_o, m_rxf, tx_flush_o, m_txf, cause_o, m_cause[7:0]);
      end
    end
  end

  // ---------------- directed helpers ----------------
  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #(CLK_P/4);
  endtask

  task automatic wr(int sel, int data);
    cfg_we_i = 1; cfg_sel_i = sel[2:0]; cfg_data_i = data[15:0];
    cyc();
    cfg_we_i = 0;
  endtask

  task automatic rx_one();
    rx_pkt_i = 1; cyc(); rx_pkt_i = 0;
  endtask

  task automatic tx_one();
    tx_pkt_i = 1; cyc(); tx_pkt_i = 0;
  endtask

  task automatic ticks(int n);
    tick_i = 1; repeat (n) cyc(); tick_i = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int fl;
    repeat (3) cyc();
    started = 1;
    chk("R1 irq", irq_o, 0); chk("R1 cause", cause_o, 0);
    rst = 0;
    cyc();
    chk("R1 irq after", irq_o, 0); chk("R1 flush", rx_flush_o | tx_flush_o, 0);

    wr(0, 8'h83);
    cause_post_i = 8'h02; cyc(); cause_post_i = 0;
    chk("R2 cause", cause_o, 8'h02); chk("R2 irq", irq_o, 1);
    wr(1, 8'h02);
    chk("R11 clear cause", cause_o, 0); chk("R11 irq drop", irq_o, 0);

    cause_post_i = 8'h04; cyc(); cause_post_i = 0;
    chk("R3 masked no irq", irq_o, 0);
    wr(0, 8'h87); chk("R3 unmask raises", irq_o, 1);
    wr(0, 8'h83); chk("R3 mask drops", irq_o, 0);
    cause_rd_i = 1; cyc(); cause_rd_i = 0;
    chk("R11 read clear", cause_o, 0);

    wr(2, 3);
    rx_one(); ticks(2); rx_one(); ticks(2);
    chk("R4 no early flush", rx_flush_o, 0); chk("R4 no early cause", cause_o, 0);
    ticks(1);
    chk("R4 flush", rx_flush_o, 1); chk("R4 cause bit7", cause_o, 8'h80);
    cyc(); chk("R4 pulse ends", rx_flush_o, 0);
    wr(1, 8'h80); wr(2, 0);

    wr(3, 4);
    rx_one(); ticks(2); rx_one(); ticks(1);
    chk("R5 not restarted yet", rx_flush_o, 0);
    ticks(1);
    chk("R5 absolute flush", rx_flush_o, 1);
    wr(1, 8'h80); wr(3, 0);

    rx_one(); tx_one(); ticks(10);
    chk("R7 zero limit no cause", cause_o, 0); chk("R7 irq", irq_o, 0);

    wr(4, 2);
    tx_one(); ticks(1); tx_one(); ticks(1);
    chk("R6 tx delay early", tx_flush_o, 0);
    ticks(1);
    chk("R6 tx delay flush", tx_flush_o, 1); chk("R6 cause bit0", cause_o, 8'h01);
    wr(1, 1); wr(4, 0);
    wr(5, 3);
    tx_one(); ticks(1); tx_one(); ticks(1);
    chk("R6 tx abs early", tx_flush_o, 0);
    ticks(1);
    chk("R6 tx abs flush", tx_flush_o, 1);
    wr(1, 1); wr(5, 0);

    wr(2, 5); wr(3, 2);
    rx_one();
    fl = 0; tick_i = 1;
    for (int k = 0; k < 8; k++) begin cyc(); fl += rx_flush_o; end
    tick_i = 0;
    chk("R12 single flush per pair", fl, 1);
    wr(1, 8'h80); wr(2, 0); wr(3, 0);

    wr(6, 3);
    cause_post_i = 8'h02; cyc(); cause_post_i = 0;
    chk("R9 first rise", irq_o, 1);
    wr(1, 2);
    cause_post_i = 8'h02; cyc(); cause_post_i = 0;
    chk("R9 held by throttle", irq_o, 0);
    ticks(2); chk("R9 still held", irq_o, 0);
    ticks(1); chk("R9 held at zero edge", irq_o, 0);
    cyc(); chk("R9 released", irq_o, 1);

    wr(1, 2); chk("R11 drop", irq_o, 0);
    wr(2, 1);
    rx_one(); ticks(1);
    chk("R8 immediate irq", irq_o, 1); chk("R8 cause", cause_o, 8'h80);
    wr(1, 8'h82); wr(2, 0);

    tx_wb_done_i = 1; cyc(); tx_wb_done_i = 0;
    chk("R10 cause bit0", cause_o, 8'h01); chk("R10 throttled", irq_o, 0);
    ticks(3); chk("R10 still held", irq_o, 0);
    cyc(); chk("R10 released", irq_o, 1);
    wr(1, 1); wr(6, 0);

    for (int k = 0; k < 4000; k++) begin
      int s;
      tick_i       = ($urandom % 2) == 0;
      rx_pkt_i     = ($urandom % 12) == 0;
      tx_pkt_i     = ($urandom % 12) == 0;
      tx_wb_done_i = ($urandom % 30) == 0;
      cause_rd_i   = ($urandom % 40) == 0;
      cause_post_i = (($urandom % 25) == 0) ? 8'($urandom) : 8'h00;
      cfg_we_i     = ($urandom % 15) == 0;
      s = $urandom % 7;
      cfg_sel_i    = s[2:0];
      cfg_data_i   = (s < 2) ? 16'($urandom % 256) : 16'($urandom % 6);
      cyc();
    end
    {tick_i, rx_pkt_i, tx_pkt_i, tx_wb_done_i, cause_rd_i, cfg_we_i} = '0;
    cause_post_i = 0;
    cyc();
    summary();
    $finish;
  end

endmodule